// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Sequencer

This block is the control front end of a peripheral. It owns one 32-bit control word that software can reach three ways. A plain write replaces the whole word. A set alias ORs the written ones into the word. A clear alias removes the written ones from the word. A fourth, read-only word reports what the sequencer is doing.

Two bits of the control word drive the peripheral: a soft-reset request and a clock-gate flag. When software raises soft-reset, the block holds the downstream logic in synchronous reset and counts a fixed number of cycles. This count stands for the internal reset completing. When the count finishes, the block sets the clock-gate flag on its own, and software takes that as the signal that the reset has finished. Software then drops soft-reset, clears clock-gate, and polls until the clock runs again.

The remaining 30 bits form a general configuration field. That field is held at zero for as long as soft-reset is set.

Top module: `ssr_ctrl`

## Requirements
- R1: After the reset input is released, the control word reads 0x00000000, `clk_en` is 1 and `periph_rst` is 0.
- R2: A write to byte offset 0x0 replaces the control word. Its fields are: bit 31 soft-reset, bit 30 clock-gate, bits 29:0 configuration.
- R3: A write to byte offset 0x4 sets only the bits that are 1 in the written data. All other bits keep their values.
- R4: A write to byte offset 0x8 clears only the bits that are 1 in the written data. All other bits keep their values.
- R5: While soft-reset reads 1, the configuration field reads 0. Writes to it through any of the three offsets are ignored, including a plain write that clears soft-reset in the same access. After soft-reset is cleared, the field stays 0.
- R6: The block sets clock-gate on its own exactly RST_CYCLES clock cycles (default 4) after soft-reset first reads 1, and not earlier.
- R7: If soft-reset is cleared before the count completes, clock-gate is not set. The next assertion of soft-reset restarts the full count.
- R8: A clear of soft-reset reads back as 0 on the next cycle, and clock-gate stays 1 until software clears it.
- R9: `clk_en` is always the inverse of clock-gate. Clearing clock-gate makes `clk_en` 1 on the next cycle.
- R10: `periph_rst` equals the soft-reset bit at all times.
- R11: Byte offset 0xC reads the status word: bit 0 clock running, bit 1 reset count in progress, bit 2 reset complete with soft-reset still held. Writes to 0xC change nothing.
- R12: The full sequence completes with the clock running and the peripheral out of reset. The sequence is: clear soft-reset, clear clock-gate, set soft-reset, poll for clock-gate 1, clear soft-reset, clear clock-gate, poll for clock-gate 0.
- R13: An access whose address bits 1:0 are not zero writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | 4 | Byte address within the block |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| clk_en | output | 1 | Clock enable for the peripheral, low while gated |
| periph_rst | output | 1 | Synchronous reset for the peripheral |

## Verification
The three write paths are each driven with overlapping and disjoint bit patterns. This separates a true OR or AND-NOT merge from a plain overwrite, and it exposes an alias that is decoded to the wrong offset.

The reset count is probed in three ways:
- on every cycle after soft-reset rises, which pins the exact edge at which clock-gate appears;
- with soft-reset dropped mid-count, which shows that an aborted count neither sets clock-gate nor leaves a partial count behind;
- through the full handshake with polling loops.

Writes aimed at the configuration field during reset, at the status word, and at misaligned addresses show whether the protection and the decode hold.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int SRST_BIT  = 31;
  localparam int GATE_BIT  = 30;
  localparam int CFG_W     = 30;
  localparam int STAT_RUN  = 0;
  localparam int STAT_BUSY = 1;
  localparam int STAT_DONE = 2;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_COUNT = 2'd1,
    SQ_DONE  = 2'd2
  } seq_state_e;

  // Merge one write access into the current control word.
  function automatic word_t merge_write(reg_sel_e sel, word_t cur, word_t wd);
    word_t res;
    case (sel)
      SEL_BASE: res = wd;
      SEL_SET:  res = cur | wd;
      SEL_CLR:  res = cur & ~wd;
      default:  res = cur;
    endcase
    return res;
  endfunction

  function automatic word_t pack_status(logic run, logic busy, logic done);
    word_t s;
    s = '0;
    s[STAT_RUN]  = run;
    s[STAT_BUSY] = busy;
    s[STAT_DONE] = done;
    return s;
  endfunction
endpackage

// File: rtl/ssr_decode.sv
module ssr_decode
  import ssr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit
);
  localparam int LSB = 2;

  always_comb begin
    hit = (addr[LSB-1:0] == '0);
    sel = reg_sel_e'(addr[LSB+1:LSB]);
  end
endmodule

// File: rtl/ssr_regfile.sv
module ssr_regfile
  import ssr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     hit,
  input  reg_sel_e sel,
  input  word_t    wdata,
  input  logic     hw_gate_set,
  output word_t    ctrl_q
);
  word_t written;
  word_t ctrl_d;
  logic  wr_ok;

  assign wr_ok = wr_en && hit && (sel != SEL_STAT);

  always_comb begin
    written = wr_ok ? merge_write(sel, ctrl_q, wdata) : ctrl_q;
    ctrl_d  = '0;
    ctrl_d[SRST_BIT] = written[SRST_BIT];
    ctrl_d[GATE_BIT] = written[GATE_BIT] | hw_gate_set;
    // Configuration is held at its reset value while soft-reset is (or becomes) set.
    if (!(ctrl_q[SRST_BIT] || written[SRST_BIT]))
      ctrl_d[CFG_W-1:0] = written[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
  import ssr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  output logic hw_gate_set,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign hw_gate_set = srst && (state_q != SQ_DONE) && (cnt_q == LAST);
  assign busy        = srst && (state_q != SQ_DONE);
  assign done        = srst && (state_q == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else if (!srst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else if (hw_gate_set) begin
      state_q <= SQ_DONE;
      cnt_q   <= '0;
    end else if (state_q != SQ_DONE) begin
      state_q <= SQ_COUNT;
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              clk_en,
  output logic              periph_rst
);
  reg_sel_e sel;
  logic     hit;
  word_t    ctrl_q;
  logic     hw_gate_set;
  logic     seq_busy;
  logic     seq_done;
  word_t    status_w;

  ssr_decode u_dec (
    .addr (addr),
    .sel  (sel),
    .hit  (hit)
  );

  ssr_regfile u_rf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .hit         (hit),
    .sel         (sel),
    .wdata       (wdata),
    .hw_gate_set (hw_gate_set),
    .ctrl_q      (ctrl_q)
  );

  ssr_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (ctrl_q[SRST_BIT]),
    .hw_gate_set (hw_gate_set),
    .busy        (seq_busy),
    .done        (seq_done)
  );

  assign clk_en     = ~ctrl_q[GATE_BIT];
  assign periph_rst = ctrl_q[SRST_BIT];
  assign status_w   = pack_status(clk_en, seq_busy, seq_done);

  always_comb begin
    if (!hit)                rdata = '0;
    else if (sel == SEL_STAT) rdata = status_w;
    else                     rdata = ctrl_q;
  end
endmodule

// File: rtl/ssr_ctrl_chk.sv
module ssr_ctrl_chk
  import ssr_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              clk_en,
  input logic              periph_rst,
  input logic              hw_gate_set,
  input logic              seq_busy,
  input logic              seq_done
);
  localparam int HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          high_cnt <= '0;
    else if (!ctrl_q[SRST_BIT])          high_cnt <= '0;
    else if (high_cnt != HW'(RST_CYCLES)) high_cnt <= high_cnt + 1'b1;
  end

  AST_CFG_HELD_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[SRST_BIT] |-> (ctrl_q[CFG_W-1:0] == '0)); // R5
  AST_SET_ALIAS_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h4 && wdata[SRST_BIT]) |=> ctrl_q[SRST_BIT]); // R3
  AST_CLR_ALIAS_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h8 && wdata[SRST_BIT]) |=> !ctrl_q[SRST_BIT]); // R4
  AST_HW_GATE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    hw_gate_set |-> (high_cnt == HW'(RST_CYCLES - 1))); // R6
  AST_HW_GATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_gate_set |=> ctrl_q[GATE_BIT]); // R6
  AST_CLKEN_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en != ctrl_q[GATE_BIT]); // R9
  AST_PRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst == ctrl_q[SRST_BIT]); // R10
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy && seq_done)); // R11
endmodule

bind ssr_ctrl ssr_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .ctrl_q      (ctrl_q),
  .clk_en      (clk_en),
  .periph_rst  (periph_rst),
  .hw_gate_set (hw_gate_set),
  .seq_busy    (seq_busy),
  .seq_done    (seq_done)
);

// File: tb/sim_ssr_ctrl.sv
module sim_ssr_ctrl;
  localparam logic [31:0] SR = 32'h8000_0000;
  localparam logic [31:0] GT = 32'h4000_0000;
  localparam int          NCYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en;
  logic        periph_rst;
  int          checks = 0;
  int          errors = 0;

  ssr_ctrl #(.RST_CYCLES(NCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .clk_en(clk_en), .periph_rst(periph_rst)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write on the next rising edge; returns at the falling edge after it.
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'h0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
    addr = 4'h0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v);
    chk("R1 ctrl", v, 32'h0);
    chk("R1 clk_en", {31'b0, clk_en}, 32'd1);
    chk("R1 periph_rst", {31'b0, periph_rst}, 32'd0);
  endtask

  task automatic t_base_write();
    logic [31:0] v;
    wr(4'h0, 32'h1234_5678);
    rd(4'h0, v); chk("R2 base replace", v, 32'h1234_5678);
    wr(4'h0, GT | 32'h0000_00A5);
    rd(4'h0, v); chk("R2 base replace with gate", v, GT | 32'h0000_00A5);
    chk("R9 clk_en low when gated", {31'b0, clk_en}, 32'd0);
    wr(4'h0, 32'h0000_00F0);
    rd(4'h0, v); chk("R2 base overwrite", v, 32'h0000_00F0);
    chk("R9 clk_en back high", {31'b0, clk_en}, 32'd1);
  endtask

  task automatic t_set_clr();
    logic [31:0] v;
    wr(4'h4, 32'h0000_003F);
    rd(4'h0, v); chk("R3 set alias merges", v, 32'h0000_00FF);
    wr(4'h8, 32'h0000_0330);
    rd(4'h0, v); chk("R4 clr alias removes", v, 32'h0000_00CF);
    wr(4'h4, 32'h0);
    rd(4'h0, v); chk("R3 set of zero is no-op", v, 32'h0000_00CF);
  endtask

  task automatic t_rst_timing();
    logic [31:0] v;
    wr(4'h4, SR);
    rd(4'h0, v); chk("R5 cfg cleared in reset", v, SR);
    chk("R10 periph_rst high", {31'b0, periph_rst}, 32'd1);
    rd(4'hC, v); chk("R11 status busy", v, 32'h3);
    for (int i = 1; i < NCYC; i++) begin
      @(negedge clk);
      chk("R6 gate not early", {31'b0, clk_en}, 32'd1);
    end
    @(negedge clk);
    rd(4'h0, v); chk("R6 gate rises on time", v, SR | GT);
    rd(4'hC, v); chk("R11 status done", v, 32'h4);
    wr(4'h0, SR | GT | 32'h55);
    rd(4'h0, v); chk("R5 base write to cfg ignored", v, SR | GT);
    wr(4'h4, 32'hAA);
    rd(4'h0, v); chk("R5 set write to cfg ignored", v, SR | GT);
    wr(4'h0, GT | 32'h77);
    rd(4'h0, v); chk("R5 cfg ignored while leaving reset", v, GT);
    chk("R10 periph_rst low", {31'b0, periph_rst}, 32'd0);
    wr(4'h8, GT);
    rd(4'h0, v); chk("R9 gate cleared", v, 32'h0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(4'h4, SR);
    @(negedge clk);
    wr(4'h8, SR);
    repeat (6) @(negedge clk);
    rd(4'h0, v); chk("R7 aborted count leaves gate clear", v, 32'h0);
    wr(4'h4, SR);
    for (int i = 1; i < NCYC; i++) begin
      @(negedge clk);
      chk("R7 restarted count not early", {31'b0, clk_en}, 32'd1);
    end
    @(negedge clk);
    chk("R7 restarted count completes", {31'b0, clk_en}, 32'd0);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_sequence();
    logic [31:0] v;
    int n;
    wr(4'h8, SR);
    wr(4'h8, GT);
    wr(4'h4, SR);
    n = 0;
    do begin @(negedge clk); rd(4'h0, v); n++; end while (!v[30] && n < 20);
    chk("R12 gate seen during handshake", {31'b0, v[30]}, 32'd1);
    wr(4'h8, SR);
    rd(4'h0, v); chk("R8 srst reads 0, gate held", v, GT);
    repeat (100) @(negedge clk);
    rd(4'h0, v); chk("R8 gate still held", v, GT);
    wr(4'h8, GT);
    n = 0;
    do begin rd(4'h0, v); if (v[30]) @(negedge clk); n++; end while (v[30] && n < 20);
    chk("R12 gate cleared", v, 32'h0);
    chk("R12 clock running", {30'b0, clk_en, periph_rst}, 32'h2);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    wr(4'h0, 32'h0000_0011);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R11 status write ignored", v, 32'h0000_0011);
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h6, 32'h0000_0000);
    rd(4'h0, v); chk("R13 misaligned write ignored", v, 32'h0000_0011);
    rd(4'h5, v); chk("R13 misaligned read zero", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_write();
    t_set_clr();
    t_rst_timing();
    t_abort();
    t_sequence();
    t_decode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule